// File: doc/BRIEF.md
# Branch Condition and Call/Return Unit

This unit decides where a program goes next. Each valid instruction presents an 8-bit opcode, a 4-bit register-select field, two 64-bit operands, a 32-bit immediate and a signed 16-bit offset. The unit holds the program counter, which counts whole 64-bit instruction slots. On the next clock edge it moves that counter on by one slot, or moves it to a branch target. The low three opcode bits give the class. Class 5 compares the full operands and class 6 compares only their low halves. The top four bits give the operation. Bit 3 chooses whether the second comparand is the source register or the sign-extended immediate.

Calls into the same program push their return slot onto an internal stack of eight entries. A return pops that stack. When a return finds the stack empty, the program has finished: the unit raises a sticky halt and ignores every instruction after it. A call to an external helper is passed out as a one-cycle request that carries the immediate and a flag giving how the helper is identified. The helper's work is done elsewhere.

Top module: `flow_ctl_unit`

## Requirements
- R1: Reset state: PC is 0, and the halt, taken, helper request and overflow outputs are all low.
- R2: A valid instruction whose class is neither 5 nor 6 advances the PC by 1 with taken low. An idle cycle (valid low) leaves the PC unchanged.
- R3: Class 5 conditions compare all 64 bits and use these codes in opcode[7:4]: 1 equal, 5 not equal, 2/3/A/B unsigned >, >=, <, <=, and 6/7/C/D signed >, >=, <, <=. When the condition holds, the PC becomes PC+1+offset, with the offset sign-extended and the result wrapping in the PC width, and taken is high. Otherwise the PC becomes PC+1.
- R4: Class 6 applies the same condition codes to the low 32 bits only. For example, opcode 0x7E is a signed >= compare of the two register values.
- R5: When opcode bit 3 is 1, the source register is the comparand. When it is 0, the immediate is the comparand, sign-extended to 64 bits.
- R6: Code 4 (bit test) is taken when the AND of the two comparands is nonzero.
- R7: Code 0 in class 5 always jumps to PC+1+offset. Codes 0, 8 and 9 in class 6, and codes E and F in either class, only advance the PC by 1.
- R8: Code 8 in class 5 with register-select field 1 pushes PC+1 onto the return stack and jumps to PC+1+offset.
- R9: Code 9 in class 5 with a non-empty stack pops the most recent return slot into the PC, in last-in first-out order.
- R10: Code 9 in class 5 with an empty stack sets halt. Halt stays set until reset, and the PC and all outputs then ignore further instructions.
- R11: Code 8 in class 5 with register-select field 0 or 2 gives a one-cycle helper request carrying the immediate. The kind flag is 0 for field 0 and 1 for field 2. The PC advances by 1. Any other field value only advances the PC.
- R12: A local call when the stack already holds 8 entries gives a one-cycle overflow pulse. The PC and the stack are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_vld | input | 1 | Instruction present this cycle |
| ins_op | input | 8 | Opcode |
| ins_sel | input | 4 | Register-select field (call kind for code 8) |
| opd_dst | input | 64 | Destination operand value |
| opd_src | input | 64 | Source operand value |
| ins_imm | input | 32 | Immediate |
| ins_off | input | 16 | Signed slot offset |
| pc_o | output | 16 | Current program counter in slots |
| taken_o | output | 1 | Last instruction redirected the PC |
| hlp_req_o | output | 1 | Helper request pulse |
| hlp_id_o | output | 32 | Helper identifier (immediate) |
| hlp_by_type_o | output | 1 | Helper named by type id rather than address |
| halt_o | output | 1 | Program has exited at the outermost level |
| ovf_err_o | output | 1 | Call rejected because the return stack is full |

## Verification
The conditions are driven with operand pairs that separate the comparison kinds. An all-ones value against a small one gives opposite answers under unsigned and signed ordering. Equal operands tell strict from non-strict compares. Values that match only in their low halves tell class 5 from class 6, and a negative immediate shows whether it is sign-extended. Nested calls and an eight-deep fill, followed by a ninth call and a full unwind, check the last-in first-out order, the overflow hold and the difference between a return and the final exit.

// File: rtl/flow_ctl_pkg.sv
package flow_ctl_pkg;
   localparam int IMM_W = 32;
   localparam int OFF_W = 16;

   localparam logic [2:0] CLS_WIDE   = 3'h5;
   localparam logic [2:0] CLS_NARROW = 3'h6;

   localparam logic [3:0] CC_ALWAYS = 4'h0;
   localparam logic [3:0] CC_EQ     = 4'h1;
   localparam logic [3:0] CC_UGT    = 4'h2;
   localparam logic [3:0] CC_UGE    = 4'h3;
   localparam logic [3:0] CC_BITS   = 4'h4;
   localparam logic [3:0] CC_NE     = 4'h5;
   localparam logic [3:0] CC_SGT    = 4'h6;
   localparam logic [3:0] CC_SGE    = 4'h7;
   localparam logic [3:0] CC_CALL   = 4'h8;
   localparam logic [3:0] CC_RET    = 4'h9;
   localparam logic [3:0] CC_ULT    = 4'hA;
   localparam logic [3:0] CC_ULE    = 4'hB;
   localparam logic [3:0] CC_SLT    = 4'hC;
   localparam logic [3:0] CC_SLE    = 4'hD;

   typedef enum logic [2:0] {
      ACT_SEQ,
      ACT_COND,
      ACT_JUMP,
      ACT_CALL,
      ACT_HLP_ADDR,
      ACT_HLP_TYPE,
      ACT_RET
   } act_e;
endpackage

// File: rtl/flow_decode.sv
module flow_decode
   import flow_ctl_pkg::*;
(
   input  logic [7:0] op,
   input  logic [3:0] sel,
   output act_e       act,
   output logic       wide
);
   logic [2:0] cls;
   logic [3:0] code;
   logic       is_flow;

   assign cls     = op[2:0];
   assign code    = op[7:4];
   assign wide    = (cls == CLS_WIDE);
   assign is_flow = (cls == CLS_WIDE) || (cls == CLS_NARROW);

   always_comb begin
      act = ACT_SEQ;
      if (is_flow) begin
         case (code)
            CC_ALWAYS: if (wide) act = ACT_JUMP;
            CC_CALL: begin
               if (wide) begin
                  case (sel)
                     4'h0:    act = ACT_HLP_ADDR;
                     4'h1:    act = ACT_CALL;
                     4'h2:    act = ACT_HLP_TYPE;
                     default: act = ACT_SEQ;
                  endcase
               end
            end
            CC_RET: if (wide) act = ACT_RET;
            CC_EQ, CC_UGT, CC_UGE, CC_BITS, CC_NE, CC_SGT, CC_SGE,
            CC_ULT, CC_ULE, CC_SLT, CC_SLE: act = ACT_COND;
            default: act = ACT_SEQ;
         endcase
      end
   end
endmodule

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
   import flow_ctl_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [3:0]        code,
   input  logic              wide,
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic              hit
);
   localparam int HALF_W = DATA_W / 2;

   if ((DATA_W % 2) != 0 || DATA_W < 2 * IMM_W) begin : g_bad_width
      $error("flow_cond_eval: DATA_W must be even and at least %0d", 2 * IMM_W);
   end

   logic eq_w, ult_w, slt_w;
   logic eq_n, ult_n, slt_n;
   logic eq, ult, slt, any_bit;

   assign eq_w  = (lhs == rhs);
   assign ult_w = (lhs < rhs);
   assign slt_w = ($signed(lhs) < $signed(rhs));

   assign eq_n  = (lhs[HALF_W-1:0] == rhs[HALF_W-1:0]);
   assign ult_n = (lhs[HALF_W-1:0] < rhs[HALF_W-1:0]);
   assign slt_n = ($signed(lhs[HALF_W-1:0]) < $signed(rhs[HALF_W-1:0]));

   assign eq      = wide ? eq_w  : eq_n;
   assign ult     = wide ? ult_w : ult_n;
   assign slt     = wide ? slt_w : slt_n;
   assign any_bit = wide ? |(lhs & rhs) : |(lhs[HALF_W-1:0] & rhs[HALF_W-1:0]);

   always_comb begin
      case (code)
         CC_EQ:   hit = eq;
         CC_NE:   hit = !eq;
         CC_UGT:  hit = !ult && !eq;
         CC_UGE:  hit = !ult;
         CC_ULT:  hit = ult;
         CC_ULE:  hit = ult || eq;
         CC_SGT:  hit = !slt && !eq;
         CC_SGE:  hit = !slt;
         CC_SLT:  hit = slt;
         CC_SLE:  hit = slt || eq;
         CC_BITS: hit = any_bit;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/flow_ret_stack.sv
module flow_ret_stack #(
   parameter int PC_W  = 16,
   parameter int DEPTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic            pop,
   input  logic [PC_W-1:0] push_addr,
   output logic [PC_W-1:0] top_addr,
   output logic            empty,
   output logic            full
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 1 || DEPTH > 64) begin : g_bad_depth
      $error("flow_ret_stack: DEPTH must lie in 1..64");
   end

   logic [PC_W-1:0]  ent [DEPTH];
   logic [CNT_W-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      end else begin
         if (push) begin
            for (int i = 0; i < DEPTH; i++)
               if (cnt == CNT_W'(i)) ent[i] <= push_addr;
            cnt <= cnt + 1'b1;
         end else if (pop) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   always_comb begin
      top_addr = '0;
      for (int i = 0; i < DEPTH; i++)
         if ((i + 1) == int'(cnt)) top_addr = ent[i];
   end

   AST_RS_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R12
   AST_RS_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R10
   AST_RS_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop)); // R9
   AST_RS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH)); // R12
endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
   import flow_ctl_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int PC_W     = 16,
   parameter int RS_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_vld,
   input  logic [7:0]        ins_op,
   input  logic [3:0]        ins_sel,
   input  logic [DATA_W-1:0] opd_dst,
   input  logic [DATA_W-1:0] opd_src,
   input  logic [IMM_W-1:0]  ins_imm,
   input  logic [OFF_W-1:0]  ins_off,
   output logic [PC_W-1:0]   pc_o,
   output logic              taken_o,
   output logic              hlp_req_o,
   output logic [IMM_W-1:0]  hlp_id_o,
   output logic              hlp_by_type_o,
   output logic              halt_o,
   output logic              ovf_err_o
);
   if (PC_W < OFF_W) begin : g_bad_pc
      $error("flow_ctl_unit: PC_W must be at least %0d", OFF_W);
   end

   act_e              act;
   logic              wide, hit, fire;
   logic [DATA_W-1:0] rhs;
   logic [PC_W-1:0]   pc_q, seq_pc, tgt_pc, top_addr, pc_d;
   logic              rs_empty, rs_full, rs_push, rs_pop;
   logic              taken_d, req_d, kind_d, halt_d, ovf_d;
   logic              halt_q;

   flow_decode u_dec (
      .op   (ins_op),
      .sel  (ins_sel),
      .act  (act),
      .wide (wide)
   );

   assign rhs = ins_op[3] ? opd_src : DATA_W'($signed(ins_imm));

   flow_cond_eval #(.DATA_W(DATA_W)) u_cond (
      .code (ins_op[7:4]),
      .wide (wide),
      .lhs  (opd_dst),
      .rhs  (rhs),
      .hit  (hit)
   );

   flow_ret_stack #(.PC_W(PC_W), .DEPTH(RS_DEPTH)) u_rs (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rs_push),
      .pop       (rs_pop),
      .push_addr (seq_pc),
      .top_addr  (top_addr),
      .empty     (rs_empty),
      .full      (rs_full)
   );

   assign fire   = ins_vld && !halt_q;
   assign seq_pc = pc_q + 1'b1;
   assign tgt_pc = seq_pc + PC_W'($signed(ins_off));

   always_comb begin
      pc_d    = seq_pc;
      taken_d = 1'b0;
      req_d   = 1'b0;
      kind_d  = 1'b0;
      halt_d  = 1'b0;
      ovf_d   = 1'b0;
      rs_push = 1'b0;
      rs_pop  = 1'b0;
      case (act)
         ACT_COND: begin
            taken_d = hit;
            if (hit) pc_d = tgt_pc;
         end
         ACT_JUMP: begin
            taken_d = 1'b1;
            pc_d    = tgt_pc;
         end
         ACT_CALL: begin
            if (rs_full) begin
               ovf_d = 1'b1;
               pc_d  = pc_q;
            end else begin
               rs_push = fire;
               taken_d = 1'b1;
               pc_d    = tgt_pc;
            end
         end
         ACT_HLP_ADDR: req_d = 1'b1;
         ACT_HLP_TYPE: begin
            req_d  = 1'b1;
            kind_d = 1'b1;
         end
         ACT_RET: begin
            if (rs_empty) begin
               halt_d = 1'b1;
               pc_d   = pc_q;
            end else begin
               rs_pop  = fire;
               taken_d = 1'b1;
               pc_d    = top_addr;
            end
         end
         default: pc_d = seq_pc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q          <= '0;
         taken_o       <= 1'b0;
         hlp_req_o     <= 1'b0;
         hlp_id_o      <= '0;
         hlp_by_type_o <= 1'b0;
         halt_q        <= 1'b0;
         ovf_err_o     <= 1'b0;
      end else if (fire) begin
         pc_q      <= pc_d;
         taken_o   <= taken_d;
         hlp_req_o <= req_d;
         ovf_err_o <= ovf_d;
         halt_q    <= halt_d;
         if (req_d) begin
            hlp_id_o      <= ins_imm;
            hlp_by_type_o <= kind_d;
         end
      end else begin
         taken_o   <= 1'b0;
         hlp_req_o <= 1'b0;
         ovf_err_o <= 1'b0;
      end
   end

   assign pc_o   = pc_q;
   assign halt_o = halt_q;

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> halt_q); // R10
   AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> $stable(pc_q)); // R10
   AST_OVF_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err_o |-> (pc_q == $past(pc_q))); // R12
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({taken_o, hlp_req_o, ovf_err_o}) <= 1); // R11
   AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> !hlp_req_o && !ovf_err_o && !taken_o); // R10
endmodule

// File: tb/flow_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module flow_ctl_unit_tb_top;
   localparam int PCW = 16;
   localparam int PC_MASK = (1 << PCW) - 1;
   localparam int STK = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_vld = 1'b0;
   logic [7:0]  ins_op = '0;
   logic [3:0]  ins_sel = '0;
   logic [63:0] opd_dst = '0, opd_src = '0;
   logic [31:0] ins_imm = '0;
   logic [15:0] ins_off = '0;
   logic [PCW-1:0] pc_o;
   logic        taken_o, hlp_req_o, hlp_by_type_o, halt_o, ovf_err_o;
   logic [31:0] hlp_id_o;

   int total = 0, bad = 0;
   int m_pc = 0;
   bit m_halt = 0;
   int m_stk[$];
   bit e_tk, e_hr, e_hk, e_ovf;
   logic [31:0] e_hid;

   always #10 clk = ~clk;

   flow_ctl_unit dut_i (
      .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_op(ins_op),
      .ins_sel(ins_sel), .opd_dst(opd_dst), .opd_src(opd_src),
      .ins_imm(ins_imm), .ins_off(ins_off), .pc_o(pc_o), .taken_o(taken_o),
      .hlp_req_o(hlp_req_o), .hlp_id_o(hlp_id_o), .hlp_by_type_o(hlp_by_type_o),
      .halt_o(halt_o), .ovf_err_o(ovf_err_o)
   );

   function automatic bit cond_ok(int code, bit wide, logic [63:0] a, logic [63:0] b);
      longint unsigned ua, ub;
      longint sa, sb;
      if (wide) begin
         ua = a; ub = b; sa = a; sb = b;
      end else begin
         ua = {32'h0, a[31:0]}; ub = {32'h0, b[31:0]};
         sa = longint'($signed(a[31:0])); sb = longint'($signed(b[31:0]));
      end
      case (code)
         1:  return ua == ub;
         5:  return ua != ub;
         2:  return ua > ub;
         3:  return ua >= ub;
         10: return ua < ub;
         11: return ua <= ub;
         6:  return sa > sb;
         7:  return sa >= sb;
         12: return sa < sb;
         13: return sa <= sb;
         4:  return (ua & ub) != 0;
         default: return 0;
      endcase
   endfunction

   task automatic model(bit v, logic [7:0] op, logic [3:0] sf, logic [63:0] d,
                        logic [63:0] s, logic [31:0] imm, logic [15:0] off);
      int cls = int'(op[2:0]);
      int code = int'(op[7:4]);
      bit wide = (cls == 5);
      int seq = (m_pc + 1) & PC_MASK;
      int tgt = (m_pc + 1 + int'($signed(off))) & PC_MASK;
      logic [63:0] b = op[3] ? s : 64'(longint'($signed(imm)));
      e_tk = 0; e_hr = 0; e_hk = 0; e_ovf = 0; e_hid = imm;
      if (!v || m_halt) return;
      if (cls != 5 && cls != 6) begin m_pc = seq; return; end
      if (code == 0) begin
         if (wide) begin m_pc = tgt; e_tk = 1; end else m_pc = seq;
      end else if (code == 8) begin
         if (wide && sf == 1) begin
            if (m_stk.size() == STK) e_ovf = 1;
            else begin m_stk.push_back(seq); m_pc = tgt; e_tk = 1; end
         end else if (wide && (sf == 0 || sf == 2)) begin
            e_hr = 1; e_hk = (sf == 2); m_pc = seq;
         end else m_pc = seq;
      end else if (code == 9) begin
         if (!wide) m_pc = seq;
         else if (m_stk.size() == 0) m_halt = 1;
         else begin m_pc = m_stk.pop_back(); e_tk = 1; end
      end else if (cond_ok(code, wide, d, b)) begin
         m_pc = tgt; e_tk = 1;
      end else m_pc = seq;
   endtask

   task automatic compare(string tag);
      total++;
      if (pc_o !== PCW'(m_pc) || taken_o !== e_tk || hlp_req_o !== e_hr ||
          halt_o !== m_halt || ovf_err_o !== e_ovf ||
          (e_hr && (hlp_id_o !== e_hid || hlp_by_type_o !== e_hk))) begin
         bad++;
         $display("FAIL %s: got pc=%0h tk=%0b req=%0b id=%0h kind=%0b halt=%0b ovf=%0b exp pc=%0h tk=%0b req=%0b id=%0h kind=%0b halt=%0b ovf=%0b",
                  tag, pc_o, taken_o, hlp_req_o, hlp_id_o, hlp_by_type_o, halt_o, ovf_err_o,
                  m_pc, e_tk, e_hr, e_hid, e_hk, m_halt, e_ovf);
      end
   endtask

   task automatic step(string tag, bit v, logic [7:0] op, logic [3:0] sf,
                       logic [63:0] d, logic [63:0] s, logic [31:0] imm, logic [15:0] off);
      ins_vld = v; ins_op = op; ins_sel = sf; opd_dst = d; opd_src = s;
      ins_imm = imm; ins_off = off;
      model(v, op, sf, d, s, imm, off);
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(200000 * 20);
      bad++;
      total++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      e_tk = 0; e_hr = 0; e_hk = 0; e_ovf = 0; e_hid = 0;
      compare("R1 reset");

      // R2 non-flow classes and idle
      step("R2 alu class", 1, 8'h07, 0, 0, 0, 32'h5, 16'h0010);
      step("R2 load class", 1, 8'h61, 0, 0, 0, 0, 16'h0010);
      step("R2 idle", 0, 8'h05, 0, 0, 0, 0, 16'h0010);

      // R3 wide conditions; all-ones vs one tells unsigned from signed
      step("R3 eq taken", 1, 8'h1D, 0, 64'd9, 64'd9, 0, 16'h0004);
      step("R3 eq not", 1, 8'h1D, 0, 64'd9, 64'd8, 0, 16'h0004);
      step("R3 ne", 1, 8'h5D, 0, 64'd9, 64'd8, 0, 16'hFFFE);
      step("R3 ugt", 1, 8'h2D, 0, '1, 64'd1, 0, 16'h0003);
      step("R3 sgt", 1, 8'h6D, 0, '1, 64'd1, 0, 16'h0003);
      step("R3 slt", 1, 8'hCD, 0, '1, 64'd1, 0, 16'h0002);
      step("R3 ult", 1, 8'hAD, 0, '1, 64'd1, 0, 16'h0002);
      step("R3 uge eq", 1, 8'h3D, 0, 64'd7, 64'd7, 0, 16'h0001);
      step("R3 ule", 1, 8'hBD, 0, 64'd6, 64'd7, 0, 16'h0001);
      step("R3 sge", 1, 8'h7D, 0, 64'd5, '1, 0, 16'h0005);
      step("R3 sle eq", 1, 8'hDD, 0, '1, '1, 0, 16'hFFF0);
      step("R3 ugt eq", 1, 8'h2D, 0, 64'd7, 64'd7, 0, 16'h0001);
      step("R3 wrap", 1, 8'h05, 0, 0, 0, 0, 16'h8000);

      // R4 narrow compare ignores upper half
      step("R4 eq narrow", 1, 8'h1E, 0, 64'h1_0000_0005, 64'd5, 0, 16'h0006);
      step("R4 eq wide", 1, 8'h1D, 0, 64'h1_0000_0005, 64'd5, 0, 16'h0006);
      step("R4 sge 0x7E", 1, 8'h7E, 0, 64'h0000_0001_8000_0000, 64'd1, 0, 16'h0002);
      step("R4 uge narrow", 1, 8'h3E, 0, 64'h0000_0001_8000_0000, 64'd1, 0, 16'h0002);

      // R5 comparand select and imm sign extension
      step("R5 imm sext", 1, 8'h15, 0, '1, 64'd0, 32'hFFFF_FFFF, 16'h0003);
      step("R5 use src", 1, 8'h1D, 0, 64'd3, 64'd4, 32'd3, 16'h0003);
      step("R5 use imm", 1, 8'h15, 0, 64'd3, 64'd4, 32'd3, 16'h0003);

      // R6 bit test
      step("R6 set", 1, 8'h4D, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 0, 16'h0002);
      step("R6 clear", 1, 8'h4D, 0, 64'h00F0, 64'h0F0F, 0, 16'h0002);
      step("R6 narrow hi only", 1, 8'h4E, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 16'h0002);

      // R7 always-jump and class-6 lookalikes
      step("R7 ja wide", 1, 8'h05, 0, 0, 0, 0, 16'h0020);
      step("R7 ja narrow", 1, 8'h06, 0, 0, 0, 0, 16'h0020);
      step("R7 ret narrow", 1, 8'h96, 0, 0, 0, 0, 0);
      step("R7 call narrow", 1, 8'h86, 1, 0, 0, 0, 16'h0020);
      step("R7 code E", 1, 8'hE5, 0, 0, 0, 0, 16'h0020);

      // R11 helper calls
      step("R11 helper addr", 1, 8'h85, 0, 0, 0, 32'h1234_5678, 0);
      step("R11 helper type", 1, 8'h85, 2, 0, 0, 32'hCAFE_0001, 0);
      step("R11 bad kind", 1, 8'h85, 5, 0, 0, 32'h0000_0042, 0);

      // R8 R9 nested calls and returns
      step("R8 call a", 1, 8'h85, 1, 0, 0, 0, 16'h0040);
      step("R8 call b", 1, 8'h85, 1, 0, 0, 0, 16'hFFF0);
      step("R2 body", 1, 8'h07, 0, 0, 0, 0, 0);
      step("R9 ret b", 1, 8'h95, 0, 0, 0, 0, 0);
      step("R9 ret a", 1, 8'h95, 0, 0, 0, 0, 0);

      // R12 fill and overflow
      for (int i = 0; i < STK; i++)
         step("R8 fill", 1, 8'h85, 1, 0, 0, 0, 16'(i + 2));
      step("R12 overflow", 1, 8'h85, 1, 0, 0, 0, 16'h0100);
      step("R12 after ovf", 1, 8'h07, 0, 0, 0, 0, 0);
      for (int i = 0; i < STK; i++)
         step("R9 unwind", 1, 8'h95, 0, 0, 0, 0, 0);

      // R10 final exit and ignore afterwards
      step("R10 exit", 1, 8'h95, 0, 0, 0, 0, 0);
      step("R10 halted jump", 1, 8'h05, 0, 0, 0, 0, 16'h0010);
      step("R10 halted helper", 1, 8'h85, 0, 0, 0, 32'h77, 0);
      step("R10 halted call", 1, 8'h85, 1, 0, 0, 0, 16'h0004);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule